// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Doubling

This unit performs signed 32-bit arithmetic that clamps instead of wrapping. It offers four functions: add, subtract, doubled-add and doubled-subtract. In the doubled forms the second operand is first multiplied by two, and that product clamps on its own. The sum or difference is then formed and clamps again. Any clamp at either stage sets a sticky overflow flag. Software clears the flag with a synchronous clear input.

The unit takes a 32-bit instruction word and decodes it. It returns the read indices for the two source registers, so that an external register file can supply the operand values on the same cycle. The result and the destination index appear one clock after a valid request.

Top module: `sat_arith_unit`

## Requirements
- R1: Instruction bits 22:21 form the function code. When bit 22 is 1 the second operand is doubled before use. When bit 21 is 1 the unit subtracts; when it is 0 the unit adds. So the codes are 00 add, 01 subtract, 10 doubled-add and 11 doubled-subtract.
- R2: The destination index output equals instruction bits 15:12. The second-operand read index equals bits 19:16, and the first-operand read index equals bits 3:0.
- R3: The result is the first operand (`rm_val`) plus or minus the possibly doubled second operand (`rn_val`). The first operand is always the minuend, never the subtrahend.
- R4: When doubling, a second operand at or above 0x40000000 becomes 0x7FFFFFFF and sets the flag.
- R5: When doubling, a second operand below 0xC0000000 (signed) becomes 0x80000000 and sets the flag. Exactly 0xC0000000 doubles to 0x80000000 and does not touch the flag.
- R6: The final add or subtract clamps to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow, and sets the flag when it clamps.
- R7: The flag is sticky. It stays set through any number of operations that do not clamp, and only `q_clear` or reset clears it.
- R8: When `q_clear` and a clamping valid operation fall in the same cycle, the flag is set after that edge.
- R9: `out_valid` follows `in_valid` one clock later. Result and destination update only for valid requests and hold otherwise.
- R10: After reset, `out_valid`, `q_flag`, `result` and `dest_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | First operand value |
| rn_val | input | 32 | Second operand value |
| q_clear | input | 1 | Synchronous clear of the sticky flag |
| rm_idx | output | 4 | First-operand read index |
| rn_idx | output | 4 | Second-operand read index |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Clamped result |
| dest_idx | output | 4 | Destination register index |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
The sticky flag's clear and its set can fall on the same clock edge. This happens when software clears the flag while a clamping operation is in flight. The bench provokes it by asserting `q_clear` together with a doubled-add that saturates, and also together with an operation that does not clamp. It expects the flag to end set in the first case and clear in the second.

// File: rtl/sat_pkg.sv
package sat_pkg;
  parameter int DATA_W  = 32;
  parameter int IDX_W   = 4;
  parameter int OP_LSB  = 21;
  parameter int DST_LSB = 12;
  parameter int SRC_LSB = 16;
  parameter int RM_LSB  = 0;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef struct packed {
    logic dbl;
    logic sub;
  } func_t;

  localparam word_t WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam word_t WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};
endpackage

// File: rtl/sat_double.sv
module sat_double
  import sat_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  output logic [W-1:0] val_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic pos_ovf, neg_ovf;

  always_comb begin
    pos_ovf = en_i && (val_i[W-1:W-2] == 2'b01);
    neg_ovf = en_i && (val_i[W-1:W-2] == 2'b10);
    sat_o   = pos_ovf || neg_ovf;
    if (!en_i)        val_o = val_i;
    else if (pos_ovf) val_o = MAXV;
    else if (neg_ovf) val_o = MINV;
    else              val_o = {val_i[W-2:0], 1'b0};
  end

  always_comb begin
    if (sat_o) AST_DBL_CLAMP_SIGN: assert (val_o[W-1] == val_i[W-1]); // R4
    if (en_i && !sat_o) AST_DBL_NO_CLAMP_EVEN: assert (val_o[0] == 1'b0); // R5
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff, raw;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    raw   = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    sat_o = (a_i[W-1] == b_eff[W-1]) && (raw[W-1] != a_i[W-1]);
    if (!sat_o)         res_o = raw;
    else if (a_i[W-1])  res_o = MINV;
    else                res_o = MAXV;
  end

  always_comb begin
    if (sat_o) AST_SUM_CLAMP_DIR: assert (res_o[W-1] == a_i[W-1]); // R6
  end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
  import sat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [DATA_W-1:0] rn_val,
  input  logic              q_clear,
  output logic [IDX_W-1:0]  rm_idx,
  output logic [IDX_W-1:0]  rn_idx,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  dest_idx,
  output logic              q_flag
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_sync[SYNC_STAGES-1];

  func_t func;
  word_t dbl_val, sum_val;
  logic  dbl_sat, sum_sat, any_sat;

  assign func   = func_t'(instr[OP_LSB +: 2]);
  assign rm_idx = instr[RM_LSB  +: IDX_W];
  assign rn_idx = instr[SRC_LSB +: IDX_W];

  sat_double #(.W(DATA_W)) u_dbl (
    .val_i (rn_val),
    .en_i  (func.dbl),
    .val_o (dbl_val),
    .sat_o (dbl_sat)
  );

  sat_addsub #(.W(DATA_W)) u_sum (
    .a_i   (rm_val),
    .b_i   (dbl_val),
    .sub_i (func.sub),
    .res_o (sum_val),
    .sat_o (sum_sat)
  );

  assign any_sat = dbl_sat || sum_sat;

  word_t res_d;
  idx_t  dst_d;
  logic  vld_d, q_d;

  always_comb begin
    vld_d = in_valid;
    res_d = result;
    dst_d = dest_idx;
    if (in_valid) begin
      res_d = sum_val;
      dst_d = instr[DST_LSB +: IDX_W];
    end
    q_d = q_flag;
    if (q_clear) q_d = 1'b0;
    if (in_valid && any_sat) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      dest_idx  <= '0;
      q_flag    <= 1'b0;
    end else begin
      out_valid <= vld_d;
      result    <= res_d;
      dest_idx  <= dst_d;
      q_flag    <= q_d;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(dest_idx))); // R9
  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (q_flag && !q_clear) |=> q_flag); // R7
  AST_Q_SET_WINS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && any_sat) |=> q_flag); // R8
  AST_Q_CLEARS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (q_clear && !(in_valid && any_sat)) |=> !q_flag); // R7
endmodule

// File: tb/sat_arith_unit_test.sv
module sat_arith_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rm_val = '0;
  logic [31:0] rn_val = '0;
  logic        q_clear = 1'b0;
  logic [3:0]  rm_idx, rn_idx, dest_idx;
  logic        out_valid, q_flag;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  logic exp_q = 1'b0;

  always #5 clk = ~clk;

  sat_arith_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rm_val(rm_val), .rn_val(rn_val), .q_clear(q_clear),
    .rm_idx(rm_idx), .rn_idx(rn_idx), .out_valid(out_valid),
    .result(result), .dest_idx(dest_idx), .q_flag(q_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint x, r;
    logic s;
    s = 1'b0;
    x = longint'($signed(b));
    if (op[1]) begin
      x = x * 2;
      if (x > 64'sd2147483647) begin x = 64'sd2147483647; s = 1'b1; end
      if (x < -64'sd2147483648) begin x = -64'sd2147483648; s = 1'b1; end
    end
    r = op[0] ? longint'($signed(a)) - x : longint'($signed(a)) + x;
    if (r > 64'sd2147483647) begin r = 64'sd2147483647; s = 1'b1; end
    if (r < -64'sd2147483648) begin r = -64'sd2147483648; s = 1'b1; end
    return {s, r[31:0]};
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [3:0] rn, input logic [3:0] rd, input logic [3:0] rm);
    logic [31:0] w;
    w = 32'h0100_0050;
    w[22:21] = op; w[19:16] = rn; w[15:12] = rd; w[3:0] = rm;
    return w;
  endfunction

  // one operation; checks result, dest and flag one clock later
  task automatic op_run(input string req, input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic clr, input logic [3:0] rd);
    logic [32:0] m;
    m = model(op, a, b);
    @(negedge clk);
    instr = mk(op, 4'h9, rd, 4'h3); rm_val = a; rn_val = b; in_valid = 1'b1; q_clear = clr;
    #1;
    chk({req, " R2 rn_idx"}, {28'h0, rn_idx}, 32'h9);
    chk({req, " R2 rm_idx"}, {28'h0, rm_idx}, 32'h3);
    if (clr) exp_q = 1'b0;
    if (m[32]) exp_q = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; q_clear = 1'b0;
    chk({req, " R9 valid"}, {31'h0, out_valid}, 32'h1);
    chk({req, " result"}, result, m[31:0]);
    chk({req, " R2 dest"}, {28'h0, dest_idx}, {28'h0, rd});
    chk({req, " flag"}, {31'h0, q_flag}, {31'h0, exp_q});
  endtask

  task automatic clear_q(input string req);
    @(negedge clk);
    q_clear = 1'b1;
    @(negedge clk);
    q_clear = 1'b0; exp_q = 1'b0;
    chk({req, " R7 clear"}, {31'h0, q_flag}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R10 valid", {31'h0, out_valid}, 32'h0);
    chk("R10 flag", {31'h0, q_flag}, 32'h0);
    chk("R10 result", result, 32'h0);
    chk("R10 dest", {28'h0, dest_idx}, 32'h0);
  endtask

  task automatic t_plain;
    op_run("R1 R3 add", 2'b00, 32'd100, 32'd23, 1'b0, 4'h5);
    op_run("R1 R3 sub order", 2'b01, 32'd10, 32'd3, 1'b0, 4'hA);
    op_run("R1 R3 dbl-add", 2'b10, 32'd7, 32'd5, 1'b0, 4'h1);
    op_run("R1 R3 dbl-sub", 2'b11, 32'd7, 32'd5, 1'b0, 4'hF);
  endtask

  task automatic t_double;
    op_run("R4 dbl pos clamp", 2'b10, 32'h0, 32'h4000_0000, 1'b0, 4'h2);
    chk("R4 flag set", {31'h0, q_flag}, 32'h1);
    clear_q("R4");
    op_run("R5 dbl edge", 2'b10, 32'h0, 32'hC000_0000, 1'b0, 4'h3);
    chk("R5 edge no flag", {31'h0, q_flag}, 32'h0);
    op_run("R5 dbl neg clamp", 2'b10, 32'h0, 32'hBFFF_FFFF, 1'b0, 4'h4);
    chk("R5 flag set", {31'h0, q_flag}, 32'h1);
    clear_q("R5");
    op_run("R4 R6 both stages", 2'b10, 32'h0000_0010, 32'h7FFF_FFFF, 1'b0, 4'h6);
  endtask

  task automatic t_final;
    clear_q("R6");
    op_run("R6 add pos clamp", 2'b00, 32'h7FFF_FFF0, 32'h100, 1'b0, 4'h7);
    clear_q("R6");
    op_run("R6 sub neg clamp", 2'b01, 32'h8000_0010, 32'h100, 1'b0, 4'h8);
    clear_q("R6");
    op_run("R6 sub min", 2'b01, 32'h0, 32'h8000_0000, 1'b0, 4'h9);
  endtask

  task automatic t_sticky;
    op_run("R7 sticky hold", 2'b00, 32'd1, 32'd1, 1'b0, 4'hB);
    chk("R7 still set", {31'h0, q_flag}, 32'h1);
    op_run("R7 clear on plain op", 2'b00, 32'd2, 32'd2, 1'b1, 4'hC);
    chk("R7 cleared", {31'h0, q_flag}, 32'h0);
  endtask

  task automatic t_same_cycle;
    op_run("R8 clear+sat", 2'b10, 32'h0, 32'h6000_0000, 1'b1, 4'hD);
    chk("R8 set wins", {31'h0, q_flag}, 32'h1);
  endtask

  task automatic t_idle;
    logic [31:0] held;
    held = result;
    @(negedge clk);
    instr = mk(2'b00, 4'h1, 4'h2, 4'h1); rm_val = 32'h1234; rn_val = 32'h1; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle valid", {31'h0, out_valid}, 32'h0);
    chk("R9 idle result hold", result, held);
    chk("R9 idle dest hold", {28'h0, dest_idx}, 32'hD);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_plain();
        t_double();
        t_final();
        t_sticky();
        t_same_cycle();
        t_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule